// File: doc/BRIEF.md
# Performance monitor counter unit

This block keeps a configurable number of 32-bit event counters and one 64-bit cycle counter for a processor core. Logic outside the block already maps each micro-architectural event onto a per-counter increment strobe. The block applies a global enable and a per-counter enable to those strobes, then applies a per-counter privilege and security filter. It counts, records wrap-around in a sticky overflow status, and raises a level interrupt for any overflow whose interrupt enable is set.

Software reaches the block through a single-cycle synchronous register port. Writes take effect at the clock edge. Reads are combinational from the address. Enable, interrupt-enable and overflow status each have a set view and a clear view. A select register gives indirect access to the type and value of any counter. Event number zero turns a counter into a software-driven counter, which is stepped through a dedicated write-only register. The cycle counter has a fixed index of 31. It can be slowed to one step per 64 clocks.

There is no sequencing state machine. Every function is a one-edge register update, and all priorities resolve inside that edge.

Top module: `perf_mon_unit`

Register word addresses: 0 control, 1 enable-set, 2 enable-clear, 3 interrupt-enable-set, 4 interrupt-enable-clear, 5 overflow-set, 6 overflow-clear, 7 select, 8 software step, 9 selected type, 10 selected value, 11 cycle low word, 12 cycle high word, 13 cycle filter.

## Requirements
- R1: After reset the enable, interrupt-enable and overflow views read 0, the cycle counter reads 0 and `irq` is low.
- R2: A control write stores only bits 0 (enable), 3 (divide by 64), 4 and 5. Bits 1, 2 and 6 read 0. Bits 15:11 read NUM_EVT, bits 23:16 read ID_CODE and bits 31:24 read IMPL_CODE.
- R3: In the enable, interrupt-enable and overflow registers, bit 31 belongs to the cycle counter and bit i to event counter i. Writing 1 to a set view sets the bit and writing 1 to a clear view clears it. Zeros have no effect, and bits of counters that are not implemented read 0. The select register keeps 5 bits.
- R4: A control write with bit 1 set clears every event counter to zero and leaves the cycle counter unchanged.
- R5: The cycle counter steps once per clock while control bit 0, enable bit 31 and its filter all allow it. With control bit 3 set it steps once per 64 such clocks. A control write with bit 2 set clears the counter and the divide remainder.
- R6: Address 9 reaches the type register, and address 10 the value, of the counter chosen by the select register. For an index of 31, address 9 reaches the cycle filter and address 10 the cycle low word. Other indices at or above NUM_EVT read 0, and writes to them are ignored.
- R7: An enabled event counter with a nonzero event number (type bits 9:0) steps on each clock that its `evt_in` bit is high. With event number 0 its `evt_in` bit has no effect.
- R8: Writing 1 to bit i of the software step register steps event counter i if it is enabled and allowed, and only if its event number is 0.
- R9: Type bits 31:26 filter counting. Bit 31 excludes EL1 and bit 30 excludes EL0. When non-secure, bits 29 and 28 invert those two exclusions. Bit 27 must be 1 to count at EL2. At EL3 the count is excluded when bit 31 differs from bit 26.
- R10: A counter wrap sets its overflow bit. The cycle counter wraps at bit 31 unless LONG_CYC is set. `irq` is high exactly while some overflow bit and its interrupt-enable bit are both 1, starting the cycle after the wrapping edge.
- R11: On a shared edge, a hardware overflow beats an overflow-clear write to the same bit. A counter reset beats a value write, and a value write beats an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_in | input | NUM_EVT | Per-counter event strobes |
| cur_el | input | 2 | Current privilege level 0..3 |
| non_secure | input | 1 | High in non-secure state |
| irq | output | 1 | Level overflow interrupt |

## Verification
The collision of interest is a counter wrap from the event input on the same edge as a software overflow-clear write that names the same bit. The bench preloads counter 1 with all ones. In one cycle it raises `evt_in[1]` and writes 1 to bit 1 of the overflow-clear view. It then reads the status and expects bit 1 still set. The same edge-sharing pattern is used to confirm that a value write overrides an increment, and that an event-counter reset overrides both.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [4:0] {
        RA_CTRL     = 5'd0,
        RA_EN_SET   = 5'd1,
        RA_EN_CLR   = 5'd2,
        RA_IE_SET   = 5'd3,
        RA_IE_CLR   = 5'd4,
        RA_OV_SET   = 5'd5,
        RA_OV_CLR   = 5'd6,
        RA_SEL      = 5'd7,
        RA_SWSTEP   = 5'd8,
        RA_SEL_TYPE = 5'd9,
        RA_SEL_VAL  = 5'd10,
        RA_CYC_LO   = 5'd11,
        RA_CYC_HI   = 5'd12,
        RA_CYC_FILT = 5'd13
    } reg_addr_e;

    localparam int          CYC_IDX      = 31;
    localparam logic [31:0] CTRL_WR_MASK = 32'h0000_0039;
    localparam int          CB_EN        = 0;
    localparam int          CB_EVRST     = 1;
    localparam int          CB_CYRST     = 2;
    localparam int          CB_DIV       = 3;
    localparam int          EVT_NUM_W    = 10;

    // filter field, type register bits 31:26
    typedef struct packed {
        logic excl_el1;
        logic excl_el0;
        logic ns_el1;
        logic ns_el0;
        logic incl_el2;
        logic el3_mod;
    } filt_t;

endpackage

// File: rtl/pmu_filter.sv
module pmu_filter
    import pmu_pkg::*;
(
    input  filt_t       filt,
    input  logic [1:0]  cur_el,
    input  logic        non_secure,
    output logic        allow
);
    always_comb begin
        unique case (cur_el)
            2'd0:    allow = non_secure ? ~(filt.excl_el0 ^ filt.ns_el0) : ~filt.excl_el0;
            2'd1:    allow = non_secure ? ~(filt.excl_el1 ^ filt.ns_el1) : ~filt.excl_el1;
            2'd2:    allow = filt.incl_el2;
            default: allow = ~(filt.excl_el1 ^ filt.el3_mod);
        endcase
    end
endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         wrap
);
    // priority: clear, then load, then step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     value <= '0;
        else if (clear) value <= '0;
        else if (load)  value <= load_val;
        else if (step)  value <= value + 1'b1;
    end

    assign wrap = step & ~clear & ~load & (&value);
endmodule

// File: rtl/pmu_cyc_counter.sv
module pmu_cyc_counter #(
    parameter int W     = 64,
    parameter int DIV_W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         div_en,
    input  logic         clear,
    input  logic         load_lo,
    input  logic         load_hi,
    input  logic [31:0]  load_val,
    input  logic         long_mode,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [DIV_W-1:0] rem_q;
    logic             tick;

    assign tick = run & (~div_en | (&rem_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               rem_q <= '0;
        else if (clear)           rem_q <= '0;
        else if (run && div_en)   rem_q <= rem_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       value <= '0;
        else if (clear)   value <= '0;
        else if (load_lo) value[31:0] <= load_val;
        else if (load_hi) value[W-1:32] <= load_val[W-33:0];
        else if (tick)    value <= value + 1'b1;
    end

    assign wrap = tick & ~clear & ~load_lo & ~load_hi
                & (long_mode ? (&value) : (&value[31:0]));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int          NUM_EVT   = 4,
    parameter logic [7:0]  ID_CODE   = 8'h5A,
    parameter logic [7:0]  IMPL_CODE = 8'h3C,
    parameter bit          LONG_CYC  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [4:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [1:0]         cur_el,
    input  logic               non_secure,
    output logic               irq
);
    localparam logic [31:0] IMPL_MASK = 32'h8000_0000 | ((32'd1 << NUM_EVT) - 32'd1);
    localparam logic [31:0] CTRL_CONST = {IMPL_CODE, ID_CODE, 5'(NUM_EVT), 4'b0, LONG_CYC, 6'b0};

    logic [31:0] ctrl_q, en_q, ie_q, ov_q, hw_ov;
    logic [4:0]  sel_q;
    logic        ctrl_e;
    logic        wr_ctrl, wr_en_s, wr_en_c, wr_ie_s, wr_ie_c, wr_ov_s, wr_ov_c;
    logic        wr_sel, wr_step, wr_type, wr_val, wr_cyc_lo, wr_cyc_hi, wr_cyc_f;
    logic        ev_reset, cy_reset;

    logic [NUM_EVT-1:0][31:0]          evt_cnt;
    logic [NUM_EVT-1:0][EVT_NUM_W-1:0] evt_num;
    filt_t [NUM_EVT-1:0]               evt_filt;
    logic [NUM_EVT-1:0]                evt_wrap;

    filt_t       cyc_filt_q;
    logic        cyc_allow, cyc_run, cyc_wrap;
    logic [63:0] cyc_val;
    logic [31:0] sel_type_rd, sel_val_rd;

    // write strobes
    assign wr_ctrl   = reg_we && (reg_addr == RA_CTRL);
    assign wr_en_s   = reg_we && (reg_addr == RA_EN_SET);
    assign wr_en_c   = reg_we && (reg_addr == RA_EN_CLR);
    assign wr_ie_s   = reg_we && (reg_addr == RA_IE_SET);
    assign wr_ie_c   = reg_we && (reg_addr == RA_IE_CLR);
    assign wr_ov_s   = reg_we && (reg_addr == RA_OV_SET);
    assign wr_ov_c   = reg_we && (reg_addr == RA_OV_CLR);
    assign wr_sel    = reg_we && (reg_addr == RA_SEL);
    assign wr_step   = reg_we && (reg_addr == RA_SWSTEP);
    assign wr_type   = reg_we && (reg_addr == RA_SEL_TYPE);
    assign wr_val    = reg_we && (reg_addr == RA_SEL_VAL);
    assign wr_cyc_lo = reg_we && (reg_addr == RA_CYC_LO);
    assign wr_cyc_hi = reg_we && (reg_addr == RA_CYC_HI);
    assign wr_cyc_f  = reg_we && (reg_addr == RA_CYC_FILT);

    assign ev_reset = wr_ctrl & reg_wdata[CB_EVRST];
    assign cy_reset = wr_ctrl & reg_wdata[CB_CYRST];
    assign ctrl_e   = ctrl_q[CB_EN];

    // event counters
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        logic [EVT_NUM_W-1:0] num_q;
        filt_t                filt_q;
        logic                 allow, is_sw, step, load;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                num_q  <= '0;
                filt_q <= '0;
            end else if (wr_type && sel_q == 5'(i)) begin
                num_q  <= reg_wdata[EVT_NUM_W-1:0];
                filt_q <= filt_t'(reg_wdata[31:26]);
            end
        end

        pmu_filter u_filt (
            .filt       (filt_q),
            .cur_el     (cur_el),
            .non_secure (non_secure),
            .allow      (allow)
        );

        assign is_sw = (num_q == '0);
        assign step  = ctrl_e & en_q[i] & allow
                     & (is_sw ? (wr_step & reg_wdata[i]) : evt_in[i]);
        assign load  = wr_val && (sel_q == 5'(i));

        pmu_evt_counter #(.W(32)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (ev_reset),
            .load     (load),
            .load_val (reg_wdata),
            .step     (step),
            .value    (evt_cnt[i]),
            .wrap     (evt_wrap[i])
        );

        assign evt_num[i]  = num_q;
        assign evt_filt[i] = filt_q;
    end

    // cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cyc_filt_q <= '0;
        else if (wr_cyc_f || (wr_type && sel_q == 5'(CYC_IDX)))
            cyc_filt_q <= filt_t'(reg_wdata[31:26]);
    end

    pmu_filter u_cyc_filt (
        .filt       (cyc_filt_q),
        .cur_el     (cur_el),
        .non_secure (non_secure),
        .allow      (cyc_allow)
    );

    assign cyc_run = ctrl_e & en_q[CYC_IDX] & cyc_allow;

    pmu_cyc_counter #(.W(64), .DIV_W(6)) u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cyc_run),
        .div_en    (ctrl_q[CB_DIV]),
        .clear     (cy_reset),
        .load_lo   (wr_cyc_lo || (wr_val && sel_q == 5'(CYC_IDX))),
        .load_hi   (wr_cyc_hi),
        .load_val  (reg_wdata),
        .long_mode (LONG_CYC),
        .value     (cyc_val),
        .wrap      (cyc_wrap)
    );

    // global registers
    always_comb begin
        hw_ov                = '0;
        hw_ov[NUM_EVT-1:0]   = evt_wrap;
        hw_ov[CYC_IDX]       = cyc_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            en_q   <= '0;
            ie_q   <= '0;
            ov_q   <= '0;
            sel_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_WR_MASK;
            if (wr_en_s)      en_q <= en_q | (reg_wdata & IMPL_MASK);
            else if (wr_en_c) en_q <= en_q & ~reg_wdata;
            if (wr_ie_s)      ie_q <= ie_q | (reg_wdata & IMPL_MASK);
            else if (wr_ie_c) ie_q <= ie_q & ~reg_wdata;
            // hardware overflow set has priority over a clear write
            ov_q <= ((wr_ov_s ? (ov_q | (reg_wdata & IMPL_MASK)) : ov_q)
                     & ~(wr_ov_c ? reg_wdata : 32'h0)) | hw_ov;
            if (wr_sel) sel_q <= reg_wdata[4:0];
        end
    end

    assign irq = |(ov_q & ie_q);

    // read path
    always_comb begin
        sel_type_rd = '0;
        sel_val_rd  = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel_q == 5'(i)) begin
                sel_type_rd = {evt_filt[i], 16'b0, evt_num[i]};
                sel_val_rd  = evt_cnt[i];
            end
        end
        if (sel_q == 5'(CYC_IDX)) begin
            sel_type_rd = {cyc_filt_q, 26'b0};
            sel_val_rd  = cyc_val[31:0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_CTRL:                reg_rdata = ctrl_q | CTRL_CONST;
            RA_EN_SET, RA_EN_CLR:   reg_rdata = en_q;
            RA_IE_SET, RA_IE_CLR:   reg_rdata = ie_q;
            RA_OV_SET, RA_OV_CLR:   reg_rdata = ov_q;
            RA_SEL:                 reg_rdata = {27'b0, sel_q};
            RA_SEL_TYPE:            reg_rdata = sel_type_rd;
            RA_SEL_VAL:             reg_rdata = sel_val_rd;
            RA_CYC_LO:              reg_rdata = cyc_val[31:0];
            RA_CYC_HI:              reg_rdata = cyc_val[63:32];
            RA_CYC_FILT:            reg_rdata = {cyc_filt_q, 26'b0};
            default:                reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_we,
    input logic [4:0]               reg_addr,
    input logic [31:0]              reg_wdata,
    input logic [31:0]              reg_rdata,
    input logic                     irq,
    input logic [4:0]               sel_q,
    input logic                     ctrl_en,
    input logic [NUM_EVT-1:0][31:0] evt_cnt,
    input logic [63:0]              cyc_val,
    input logic [31:0]              ov_q
);
    p_ctrl_count_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_CTRL) |-> (reg_rdata[15:11] == 5'(NUM_EVT)));

    p_evt_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_CTRL && reg_wdata[CB_EVRST]) |=> (evt_cnt == '0));

    p_cyc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !reg_we) |=> $stable(cyc_val));

    p_unimpl_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_SEL_VAL && sel_q >= 5'(NUM_EVT) && sel_q != 5'(CYC_IDX))
        |-> (reg_rdata == 32'h0));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ov_q) & ~ov_q)) |-> $past(reg_we && reg_addr == RA_OV_CLR));

    p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we));
endmodule

bind perf_mon_unit pmu_checker #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .sel_q     (sel_q),
    .ctrl_en   (ctrl_q[0]),
    .evt_cnt   (evt_cnt),
    .cyc_val   (cyc_val),
    .ov_q      (ov_q)
);

// File: tb/perf_mon_unit_test.sv
`timescale 1ns/1ps
module perf_mon_unit_test;
    localparam int NUM_EVT = 4;
    localparam logic [4:0] A_CTRL = 5'd0, A_ENS = 5'd1, A_ENC = 5'd2, A_IES = 5'd3,
        A_IEC = 5'd4, A_OVS = 5'd5, A_OVC = 5'd6, A_SEL = 5'd7, A_STEP = 5'd8,
        A_TYPE = 5'd9, A_VAL = 5'd10, A_CLO = 5'd11, A_CHI = 5'd12, A_CF = 5'd13;
    localparam int NV = 23;
    // {we, addr, wdata, expected read}
    localparam logic [69:0] VECS [0:NV-1] = '{
        {1'b0, A_CTRL, 32'h0,        32'h3C5A_2000},
        {1'b1, A_CTRL, 32'hFFFF_FFFF, 32'h0},
        {1'b0, A_CTRL, 32'h0,        32'h3C5A_2039},
        {1'b1, A_CTRL, 32'h0,        32'h0},
        {1'b0, A_CTRL, 32'h0,        32'h3C5A_2000},
        {1'b1, A_ENS,  32'hFFFF_FFFF, 32'h0},
        {1'b0, A_ENS,  32'h0,        32'h8000_000F},
        {1'b1, A_ENC,  32'h5,        32'h0},
        {1'b0, A_ENC,  32'h0,        32'h8000_000A},
        {1'b1, A_ENS,  32'h0,        32'h0},
        {1'b0, A_ENS,  32'h0,        32'h8000_000A},
        {1'b1, A_ENC,  32'hFFFF_FFFF, 32'h0},
        {1'b0, A_ENS,  32'h0,        32'h0},
        {1'b1, A_IES,  32'h8000_0003, 32'h0},
        {1'b1, A_IEC,  32'h8000_0000, 32'h0},
        {1'b0, A_IES,  32'h0,        32'h3},
        {1'b1, A_IEC,  32'hFFFF_FFFF, 32'h0},
        {1'b1, A_OVS,  32'h2,        32'h0},
        {1'b0, A_OVC,  32'h0,        32'h2},
        {1'b1, A_OVC,  32'h2,        32'h0},
        {1'b0, A_OVS,  32'h0,        32'h0},
        {1'b1, A_SEL,  32'h3F,       32'h0},
        {1'b0, A_SEL,  32'h0,        32'h1F}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_we = 1'b0;
    logic [4:0]         reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic [NUM_EVT-1:0] evt_in = '0;
    logic [1:0]         cur_el = 2'd1;
    logic               non_secure = 1'b0;
    logic               irq;
    int                 n_chk = 0;
    int                 n_bad = 0;
    bit                 done = 1'b0;

    perf_mon_unit #(.NUM_EVT(NUM_EVT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .cur_el(cur_el), .non_secure(non_secure), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            evt_in[idx] = 1'b1;
            @(negedge clk);
            evt_in = '0;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd_chk("R1 enable", A_ENS, 32'h0);
        rd_chk("R1 cycle", A_CLO, 32'h0);
        rd_chk("R1 overflow", A_OVS, 32'h0);

        // R2 / R3 register table
        for (int v = 0; v < NV; v++) begin
            if (VECS[v][69]) wr(VECS[v][68:64], VECS[v][63:32]);
            else rd_chk(v < 5 ? "R2 table" : "R3 table", VECS[v][68:64], VECS[v][31:0]);
        end

        // R6 indirect access
        wr(A_SEL, 5);
        wr(A_VAL, 32'h1234);
        rd_chk("R6 unimpl value", A_VAL, 32'h0);
        wr(A_TYPE, 32'h11);
        rd_chk("R6 unimpl type", A_TYPE, 32'h0);
        wr(A_SEL, 31);
        wr(A_TYPE, 32'hFFFF_FFFF);
        rd_chk("R6 cycle filter", A_CF, 32'hFC00_0000);
        wr(A_CF, 0);

        // R7 event counting
        wr(A_SEL, 1);
        wr(A_TYPE, 32'h11);
        wr(A_VAL, 0);
        wr(A_ENS, 32'h3);
        wr(A_CTRL, 1);
        pulse(1, 5);
        rd_chk("R7 count", A_VAL, 32'd5);
        pulse(0, 3);
        wr(A_SEL, 0);
        rd_chk("R7 type0 ignores input", A_VAL, 32'd0);

        // R8 software step
        wr(A_STEP, 32'h3);
        rd_chk("R8 sw step", A_VAL, 32'd1);
        wr(A_SEL, 1);
        rd_chk("R8 nonzero type ignores", A_VAL, 32'd5);

        // R9 filter
        wr(A_TYPE, 32'h4000_0011);
        cur_el = 2'd0;
        pulse(1, 4);
        rd_chk("R9 EL0 excluded", A_VAL, 32'd5);
        cur_el = 2'd1;
        pulse(1, 2);
        rd_chk("R9 EL1 counted", A_VAL, 32'd7);
        wr(A_TYPE, 32'h5000_0011);
        cur_el = 2'd0; non_secure = 1'b1;
        pulse(1, 1);
        rd_chk("R9 NS EL0 modifier", A_VAL, 32'd8);
        cur_el = 2'd2;
        pulse(1, 1);
        rd_chk("R9 EL2 not included", A_VAL, 32'd8);
        wr(A_TYPE, 32'h0800_0011);
        pulse(1, 1);
        rd_chk("R9 EL2 included", A_VAL, 32'd9);
        cur_el = 2'd1; non_secure = 1'b0;

        // R4 event counter reset
        wr(A_CLO, 32'h100);
        wr(A_CTRL, 32'h3);
        rd_chk("R4 counter1", A_VAL, 32'd0);
        wr(A_SEL, 0);
        rd_chk("R4 counter0", A_VAL, 32'd0);
        rd_chk("R4 cycle untouched", A_CLO, 32'h100);

        // R5 cycle counter
        wr(A_CTRL, 0);
        wr(A_CLO, 0);
        wr(A_ENS, 32'h8000_0000);
        wr(A_CTRL, 1);
        repeat (10) @(negedge clk);
        wr(A_CTRL, 0);
        rd_chk("R5 per clock", A_CLO, 32'd11);
        wr(A_CTRL, 32'h4);
        rd_chk("R5 reset", A_CLO, 32'd0);
        wr(A_CTRL, 32'h9);
        repeat (127) @(negedge clk);
        wr(A_CTRL, 32'h8);
        rd_chk("R5 divide", A_CLO, 32'd2);
        wr(A_CTRL, 32'h9);
        repeat (39) @(negedge clk);
        wr(A_CTRL, 32'h4);
        wr(A_CTRL, 32'h9);
        repeat (29) @(negedge clk);
        wr(A_CTRL, 32'h8);
        rd_chk("R5 remainder cleared", A_CLO, 32'd0);

        // R10 overflow and interrupt
        wr(A_CTRL, 0);
        wr(A_SEL, 1);
        wr(A_VAL, 32'hFFFF_FFFE);
        wr(A_OVC, 32'hFFFF_FFFF);
        wr(A_IES, 32'h2);
        wr(A_CTRL, 1);
        pulse(1, 1);
        check("R10 no irq before wrap", {31'b0, irq}, 32'h0);
        rd_chk("R10 at max", A_VAL, 32'hFFFF_FFFF);
        pulse(1, 1);
        check("R10 irq on wrap", {31'b0, irq}, 32'h1);
        rd_chk("R10 status", A_OVS, 32'h2);
        rd_chk("R10 wrapped value", A_VAL, 32'h0);
        wr(A_IEC, 32'h2);
        check("R10 irq masked", {31'b0, irq}, 32'h0);
        rd_chk("R10 status sticky", A_OVS, 32'h2);
        wr(A_CTRL, 0);
        wr(A_ENC, 32'h3);
        wr(A_CLO, 32'hFFFF_FFFF);
        wr(A_CHI, 0);
        wr(A_OVC, 32'hFFFF_FFFF);
        wr(A_IES, 32'h8000_0000);
        wr(A_CTRL, 1);
        wr(A_CTRL, 0);
        rd_chk("R10 cycle high", A_CHI, 32'h1);
        rd_chk("R10 cycle low", A_CLO, 32'h0);
        rd_chk("R10 cycle status", A_OVS, 32'h8000_0000);
        check("R10 cycle irq", {31'b0, irq}, 32'h1);

        // R11 same-edge priorities
        wr(A_OVC, 32'hFFFF_FFFF);
        wr(A_IEC, 32'hFFFF_FFFF);
        wr(A_ENS, 32'h2);
        wr(A_SEL, 1);
        wr(A_VAL, 32'hFFFF_FFFF);
        wr(A_CTRL, 1);
        evt_in[1] = 1'b1;
        wr(A_OVC, 32'h2);
        evt_in = '0;
        rd_chk("R11 overflow beats clear", A_OVS, 32'h2);
        rd_chk("R11 wrapped", A_VAL, 32'h0);
        evt_in[1] = 1'b1;
        wr(A_VAL, 32'h50);
        evt_in = '0;
        rd_chk("R11 write beats step", A_VAL, 32'h50);
        evt_in[1] = 1'b1;
        wr(A_CTRL, 32'h3);
        evt_in = '0;
        rd_chk("R11 reset beats step", A_VAL, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule